// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives PHY management transactions over a two-wire serial management bus (MDC clock, bidirectional MDIO data). Software programs a speed-control register with a clock divider and a preamble-skip bit. A write to the 32-bit frame register then starts a transaction. The block optionally sends a run of ones, then shifts the frame register out MSB first, with the management clock derived from the system clock.

The frame register is used directly as the shift register. It rotates during the frame and holds its original value again when the frame ends. The exception is a read frame: its low 16 bits are replaced by the bits sampled from the PHY. The frame layout, MSB first, is start(2), opcode(2), PHY address(5), register address(5), turnaround(2), data(16). Only opcode `10` is treated as a read. Every other pattern, standard or not, is sent as written.

A one-cycle completion pulse and a busy level let software avoid writing the frame register while a transaction is in flight.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The speed-control register (reg_addr=1) resets to zero. It holds the preamble-skip bit at bit 7 and the divider at bits 6:1. Bits 31:8 and bit 0 read as zero. The frame register (reg_addr=0) resets to zero.
- R2: A frame-register write made while idle with a nonzero divider starts a frame. busy is high from the next cycle until the frame ends.
- R3: Unless the skip bit is set, each frame begins with 32 MDC periods of MDIO=1 with the output enable high.
- R4: MDC is low while idle. During a frame it toggles every DIV system clocks, starting low, so one bit lasts 2*DIV clocks. MDIO changes only when MDC falls.
- R5: The 32 frame bits follow, MSB first, one per MDC period. For non-read frames the output enable stays high throughout.
- R6: For a read frame (bits 29:28 = 10), the output enable is released from the first turnaround bit (frame bit 14 from the start) through the last data bit.
- R7: For a read frame, MDIO is sampled at each MDC rising edge of the 16 data bits, MSB first. At completion the frame register holds bits 31:16 as written and bits 15:0 equal to the sampled value.
- R8: After a non-read frame, the frame register equals the value written.
- R9: Frames with non-standard start, opcode or turnaround values are sent bit for bit as written.
- R10: irq is a one-cycle pulse in the first cycle in which busy is low after a frame.
- R11: With the divider at zero, a frame-register write stores the value but starts nothing: busy stays low and MDC stays low.
- R12: A frame-register write during a frame neither restarts nor lengthens it. busy and irq keep their original timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the frame register, 1 selects speed control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or state shows up at once on MDIO. It also moves the busy fall and the irq pulse away from the exact cycle 2*DIV*(32 or 64), which the bench predicts. A bad divider counter misplaces an MDC edge within one half period. A wrong rotation or sampling slot is visible only at completion, when the frame register reads back something other than the written word or the PHY value. The bench compares the pins every clock against a behavioural model and reads the register back after each frame.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int BW       = $clog2((PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W);
  localparam int D_START  = FRAME_W - DATA_W;
  localparam int TA_START = D_START - 2;
  localparam int SKIP_BIT = DIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_FRM} st_t;

  st_t              st;
  logic [FRAME_W-1:0] fr;
  logic             skip_pre;
  logic [DIV_W-1:0] div, dcnt;
  logic [BW-1:0]    bcnt;
  logic             rd, samp, mdc_q, irq_q;

  wire active    = (st != S_IDLE);
  wire div_nz    = (div != '0);
  wire tick      = active && div_nz && (dcnt == div - 1'b1);
  wire rise      = tick && !mdc_q;
  wire fall      = tick && mdc_q;
  wire frame_wr  = reg_wr && !reg_addr;
  wire start     = frame_wr && !active && div_nz;
  wire rx_slot   = rd && (st == S_FRM) && (bcnt >= BW'(TA_START));
  wire data_slot = rd && (st == S_FRM) && (bcnt >= BW'(D_START));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fr <= '0; skip_pre <= 1'b0; div <= '0; dcnt <= '0;
      bcnt <= '0; rd <= 1'b0; samp <= 1'b0; mdc_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (reg_wr && reg_addr) begin
        skip_pre <= reg_wdata[SKIP_BIT];
        div      <= reg_wdata[DIV_W:1];
      end
      if (frame_wr) fr <= reg_wdata[FRAME_W-1:0];
      if (start) begin
        st    <= skip_pre ? S_FRM : S_PRE;
        bcnt  <= '0;
        dcnt  <= '0;
        mdc_q <= 1'b0;
        rd    <= (reg_wdata[FRAME_W-3 -: 2] == 2'b10);
      end else if (active && div_nz) begin
        dcnt <= tick ? '0 : dcnt + 1'b1;
        if (tick) mdc_q <= !mdc_q;
        if (rise) samp <= mdio_i;
        if (fall) begin
          if (st == S_PRE) begin
            if (bcnt == BW'(PRE_LEN - 1)) begin
              st   <= S_FRM;
              bcnt <= '0;
            end else bcnt <= bcnt + 1'b1;
          end else begin
            if (!frame_wr) fr <= {fr[FRAME_W-2:0], data_slot ? samp : fr[FRAME_W-1]};
            if (bcnt == BW'(FRAME_W - 1)) begin
              st    <= S_IDLE;
              irq_q <= 1'b1;
            end else bcnt <= bcnt + 1'b1;
          end
        end
      end
    end
  end

  assign busy    = active;
  assign irq     = irq_q;
  assign mdc     = mdc_q;
  assign mdio_o  = (st == S_PRE) || ((st == S_FRM) && fr[FRAME_W-1]);
  assign mdio_oe = (st == S_PRE) || ((st == S_FRM) && !rx_slot);
  assign reg_rdata = reg_addr ? 32'({skip_pre, div, 1'b0}) : 32'(fr);
endmodule

module mdio_mgmt_master_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic             busy,
  input logic             irq,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [DIV_W-1:0] div
);
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  a_r10_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (!busy && $past(busy)));
  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
  a_r5_oe_idle_off: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdio_oe);
  a_r11_no_start_div0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !busy && div == '0) |=> !busy);
  a_r4_mdio_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc) && busy && $past(busy) && !$past(reg_wr)) |-> $stable(mdio_o));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .busy(busy),
  .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .div(div)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_addr = 0, mdio_i = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic busy, irq, mdc, mdio_o, mdio_oe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_mgmt_master u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .irq(irq), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(bit a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0; d = reg_rdata;
  endtask

  // Reference: per-cycle behaviour derived from the requirements.
  task automatic run_frame(logic [31:0] w, bit skip, int div, logic [15:0] phy, int midc);
    int p = skip ? 0 : 32;
    int tend = (p + 32) * 2 * div;
    bit isrd = (w[29:28] == 2'b10);
    int e_busy = 0, e_mdc = 0, e_pre = 0, e_dat = 0, e_oe = 0, e_irq = 0;
    logic [31:0] back;
    wr(1, {24'd0, skip, 6'(div), 1'b0});
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = w;
    @(posedge clk);
    for (int c = 0; c <= tend + 2; c++) begin
      @(negedge clk);
      reg_wr = 0;
      if (c == midc) begin reg_wr = 1; reg_wdata = ~w; end
      if (c < tend) begin
        int s = c / (2 * div);
        if (!busy) e_busy++;
        if (irq) e_irq++;
        if (mdc != ((c / div) % 2)) e_mdc++;
        if (s < p) begin
          if (!(mdio_o && mdio_oe)) e_pre++;
        end else begin
          int fs = s - p;
          bit eoe = !(isrd && fs >= 14);
          if (mdio_oe != eoe) e_oe++;
          if (eoe && (midc < 0 || c < midc) && mdio_o != w[31-fs]) e_dat++;
          mdio_i = (isrd && fs >= 16) ? phy[31-fs] : 1'b0;
        end
      end else begin
        if (busy || mdc || mdio_oe) e_busy++;
        if (irq != (c == tend)) e_irq++;
      end
    end
    chk("R2 busy window", e_busy, 0);
    chk("R4 mdc timing", e_mdc, 0);
    chk("R10 irq pulse", e_irq, 0);
    if (midc < 0) begin
      chk(skip ? "R3 preamble skipped" : "R3 preamble", e_pre, 0);
      chk(isrd ? "R6 oe release" : "R5 oe held", e_oe, 0);
      chk("R5 R9 bit order", e_dat, 0);
      rd_reg(0, back);
      if (isrd) chk("R7 read capture", back, {w[31:16], phy});
      else chk("R8 register restored", back, w);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R4 reset mdc", mdc, 0);
    rd_reg(1, v); chk("R1 speed reset", v, 0);
    rd_reg(0, v); chk("R1 frame reset", v, 0);
    wr(1, 32'hFFFF_FFFF);
    rd_reg(1, v); chk("R1 field mask", v, 32'h0000_00FE);
    wr(1, 32'h0);
    wr(0, 32'h1234_5678);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || mdc) chk("R11 no start with div0", {busy, mdc}, 0);
    end
    chk("R11 idle after div0 write", busy, 0);
    rd_reg(0, v); chk("R11 value stored", v, 32'h1234_5678);

    run_frame({2'b01, 2'b01, 5'h0A, 5'h13, 2'b10, 16'hBEEF}, 0, 2, 16'h0, -1);
    run_frame({2'b01, 2'b10, 5'h11, 5'h02, 2'b10, 16'h1234}, 1, 3, 16'hA5C3, -1);
    run_frame({2'b11, 2'b00, 5'h1F, 5'h00, 2'b01, 16'h0F0F}, 1, 1, 16'h0, -1);
    run_frame({2'b01, 2'b10, 5'h01, 5'h1E, 2'b10, 16'hFFFF}, 0, 1, 16'h8001, -1);
    run_frame({2'b01, 2'b01, 5'h05, 5'h05, 2'b10, 16'h5555}, 1, 2, 16'h0, 41); // R12

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule